// File: doc/BRIEF.md
# Vector Indexed Atomic Element Sequencer

This block carries out one vector atomic read-modify-write instruction. It works through its elements one at a time and sends one atomic request to memory for each element that takes part. On a start pulse it captures the following:

- the instruction fields: offset-width code, operation code, mask enable and write-back;
- a scalar base address and the element width (SEW);
- the vector length and a mask vector;
- one packed vector of byte offsets, one of source data, and the current destination register contents.

For each element that takes part, the block adds a zero-extended offset to the base address. It then issues a request on a valid/ready port that carries the address, the source data, the operation code and the element size. The offset width comes from the width code, not from SEW.

Memory returns responses in the order of the requests. When write-back is on, each returned old value is merged into its destination element. When write-back is off, the destination stays as it was, and each request tells memory that no old value is needed. Reserved encodings are rejected at start. A rejected instruction raises an illegal flag and issues no memory traffic.

Top module: `vamo_seq`

## Requirements
- R1: The width code picks the offset width: 3'b000 gives 8 bits, 3'b101 gives 16 bits, 3'b110 gives 32 bits and 3'b111 gives 64 bits. Element i's offset is lane i of `offsets`, at bits [64i+63:64i]. Only the low offset-width bits of that lane are used, zero-extended. `req_addr` equals `base_addr` plus that value, modulo 2^XLEN.
- R2: Width codes 3'b001, 3'b010, 3'b011 and 3'b100 are rejected. In the cycle after the start pulse, `illegal` and `done` are both high for one cycle. No request is issued, and `busy` stays low.
- R3: An offset width wider than XLEN is rejected in the same way as R2. With XLEN=32, this applies to width code 3'b111.
- R4: `sew_code` is encoded as 0 for 8 bits, 1 for 16, 2 for 32 and 3 for 64. Only 32 bits is accepted, plus 64 bits when XLEN is 64. Any other value is rejected as in R2.
- R5: With write-back set, each response replaces the low SEW bits of its element's destination lane. The lane's upper bits are kept. Destination lane i is bits [XLEN*i+XLEN-1:XLEN*i].
- R6: With write-back clear, `dst_out` equals `dst_init` when the instruction completes, and every request has `req_need_old` at 0. With write-back set, `req_need_old` is 1.
- R7: With mask enabled, an element whose `mask_bits` bit is 0 issues no request and keeps its destination lane. With mask disabled, `mask_bits` is ignored.
- R8: Requests go out in ascending element order, at most one per cycle. One goes out in every cycle in which `req_ready` is high. While `req_ready` is low, the pending request holds its address and data.
- R9: Elements with index at or above `vec_len` issue no request and keep their destination lanes.
- R10: Each request carries the captured operation code unchanged. It also carries `sew_code` as `req_size`, and the element's source lane masked to its low SEW bits.
- R11: `done` pulses for one cycle, one cycle after the last expected response is accepted. If no element takes part, `done` pulses in the second cycle after start. No request is pending at `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins an instruction when idle |
| width_code | input | 3 | Offset-width code |
| amo_op | input | 5 | Atomic operation code, forwarded with each request |
| mask_en | input | 1 | Enables the per-element mask |
| wr_back | input | 1 | Writes old memory values to the destination |
| base_addr | input | XLEN | Scalar base address |
| sew_code | input | 2 | Element width code |
| vec_len | input | clog2(NELEM+1) | Number of elements to consider |
| mask_bits | input | NELEM | Per-element mask |
| offsets | input | NELEM*OFF_LANE | Packed byte offsets |
| src_data | input | NELEM*XLEN | Packed source operands |
| dst_init | input | NELEM*XLEN | Destination register contents before the instruction |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Completion pulse |
| illegal | output | 1 | Reserved-encoding pulse, raised with done |
| req_valid | output | 1 | Memory request valid |
| req_ready | input | 1 | Memory accepts the request |
| req_addr | output | XLEN | Element address |
| req_op | output | 5 | Operation code |
| req_data | output | XLEN | Source operand, zero above SEW |
| req_size | output | 2 | Element width code |
| req_need_old | output | 1 | Old value must be returned |
| rsp_valid | input | 1 | Response carrying an old value |
| rsp_data | input | XLEN | Old memory value |
| dst_out | output | NELEM*XLEN | Destination register contents |

## Verification
The checker assumes that memory never returns more responses than there are accepted requests still pending. It also assumes that responses come back in request order. The bench's memory model keeps to both: it queues each accepted request and returns the queued old values one per cycle, starting no earlier than the cycle after acceptance. The checker further assumes that `start` is only meaningful while the block is idle. The bench pulses start only after `done` of the previous instruction. The ready stall pattern and the offsets with junk upper bits are chosen so that the order, hold and truncation behaviour are visible at the ports.

// File: rtl/vamo_seq_pkg.sv
package vamo_seq_pkg;

   typedef enum logic [0:0] {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } seq_state_e;

   // Low-bit mask for a 2-bit size code (0:8, 1:16, 2:32, 3:64 bits)
   function automatic logic [63:0] width_mask(input logic [1:0] code);
      case (code)
         2'd0:    width_mask = 64'h0000_0000_0000_00FF;
         2'd1:    width_mask = 64'h0000_0000_0000_FFFF;
         2'd2:    width_mask = 64'h0000_0000_FFFF_FFFF;
         default: width_mask = 64'hFFFF_FFFF_FFFF_FFFF;
      endcase
   endfunction

endpackage

// File: rtl/vamo_insn_check.sv
module vamo_insn_check #(
   parameter int XLEN = 64
) (
   input  logic [2:0] width_code,
   input  logic [1:0] sew_code,
   output logic [1:0] eew_code,
   output logic       reserved
);
   logic code_ok;
   logic sew_ok;
   logic eew_fits;

   // R1 / R2: offset width from the width code; scalar codes rejected
   always_comb begin
      code_ok  = 1'b1;
      eew_code = 2'd0;
      case (width_code)
         3'b000:  eew_code = 2'd0;
         3'b101:  eew_code = 2'd1;
         3'b110:  eew_code = 2'd2;
         3'b111:  eew_code = 2'd3;
         default: code_ok  = 1'b0;
      endcase
   end

   // R3 / R4: legality depends on the scalar register width
   generate
      if (XLEN >= 64) begin : g_wide
         assign sew_ok   = (sew_code == 2'd2) || (sew_code == 2'd3);
         assign eew_fits = 1'b1;
      end else begin : g_narrow
         assign sew_ok   = (sew_code == 2'd2);
         assign eew_fits = (eew_code != 2'd3);
      end
   endgenerate

   assign reserved = !code_ok || !sew_ok || !eew_fits;

endmodule

// File: rtl/vamo_next_active.sv
module vamo_next_active #(
   parameter int NELEM = 8,
   parameter int IW    = $clog2(NELEM + 1)
) (
   input  logic [NELEM-1:0] act,
   input  logic [IW-1:0]    from,
   output logic [IW-1:0]    nxt
);
   // Lowest active index at or above 'from'; NELEM when none is left
   always_comb begin
      nxt = IW'(NELEM);
      for (int i = NELEM - 1; i >= 0; i--) begin
         if (act[i] && (IW'(i) >= from)) nxt = IW'(i);
      end
   end

endmodule

// File: rtl/vamo_seq.sv
module vamo_seq
   import vamo_seq_pkg::*;
#(
   parameter int XLEN     = 64,
   parameter int NELEM    = 8,
   parameter int OFF_LANE = 64
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          start,
   input  logic [2:0]                    width_code,
   input  logic [4:0]                    amo_op,
   input  logic                          mask_en,
   input  logic                          wr_back,
   input  logic [XLEN-1:0]               base_addr,
   input  logic [1:0]                    sew_code,
   input  logic [$clog2(NELEM+1)-1:0]    vec_len,
   input  logic [NELEM-1:0]              mask_bits,
   input  logic [NELEM*OFF_LANE-1:0]     offsets,
   input  logic [NELEM*XLEN-1:0]         src_data,
   input  logic [NELEM*XLEN-1:0]         dst_init,
   output logic                          busy,
   output logic                          done,
   output logic                          illegal,
   output logic                          req_valid,
   input  logic                          req_ready,
   output logic [XLEN-1:0]               req_addr,
   output logic [4:0]                    req_op,
   output logic [XLEN-1:0]               req_data,
   output logic [1:0]                    req_size,
   output logic                          req_need_old,
   input  logic                          rsp_valid,
   input  logic [XLEN-1:0]               rsp_data,
   output logic [NELEM*XLEN-1:0]         dst_out
);
   localparam int IW = $clog2(NELEM + 1);
   localparam int LW = $clog2(NELEM);

   generate
      if (!(XLEN == 32 || XLEN == 64)) begin : g_bad_xlen
         $error("vamo_seq: XLEN must be 32 or 64");
      end
      if (NELEM < 2) begin : g_bad_nelem
         $error("vamo_seq: NELEM must be at least 2");
      end
      if (OFF_LANE < XLEN || OFF_LANE > 64) begin : g_bad_lane
         $error("vamo_seq: OFF_LANE must lie between XLEN and 64");
      end
   endgenerate

   seq_state_e          state_q;
   logic [IW-1:0]       iss_q, rsp_q;
   logic [NELEM-1:0]    act_q;
   logic [XLEN-1:0]     base_q;
   logic [1:0]          eew_q, sew_q;
   logic [4:0]          op_q;
   logic                wb_q;
   logic                done_q, illegal_q;
   logic [OFF_LANE-1:0] off_q [NELEM];
   logic [XLEN-1:0]     src_q [NELEM];
   logic [XLEN-1:0]     dst_q [NELEM];

   logic [1:0]          dec_eew;
   logic                dec_bad;
   logic [NELEM-1:0]    act_in;
   logic [IW-1:0]       first_idx, iss_nx, rsp_nx;
   logic [LW-1:0]       iss_lane, rsp_lane;
   logic [63:0]         sew_m64, eew_m64, off64;
   logic [XLEN-1:0]     sew_m;
   logic                rsp_fire;

   vamo_insn_check #(.XLEN(XLEN)) u_dec (
      .width_code (width_code),
      .sew_code   (sew_code),
      .eew_code   (dec_eew),
      .reserved   (dec_bad)
   );

   // R7 / R9: which elements take part, from the live inputs
   generate
      for (genvar g = 0; g < NELEM; g++) begin : g_act
         assign act_in[g] = (vec_len > IW'(g)) && (!mask_en || mask_bits[g]);
      end
   endgenerate

   vamo_next_active #(.NELEM(NELEM), .IW(IW)) u_first (
      .act (act_in), .from (IW'(0)), .nxt (first_idx)
   );
   vamo_next_active #(.NELEM(NELEM), .IW(IW)) u_iss_nx (
      .act (act_q), .from (iss_q + IW'(1)), .nxt (iss_nx)
   );
   vamo_next_active #(.NELEM(NELEM), .IW(IW)) u_rsp_nx (
      .act (act_q), .from (rsp_q + IW'(1)), .nxt (rsp_nx)
   );

   assign iss_lane = iss_q[LW-1:0];
   assign rsp_lane = rsp_q[LW-1:0];
   assign sew_m64  = width_mask(sew_q);
   assign eew_m64  = width_mask(eew_q);
   assign sew_m    = sew_m64[XLEN-1:0];
   assign off64    = 64'(off_q[iss_lane]) & eew_m64;

   assign busy         = (state_q == ST_RUN);
   assign req_valid    = busy && (iss_q != IW'(NELEM));
   assign req_addr     = base_q + off64[XLEN-1:0];
   assign req_data     = src_q[iss_lane] & sew_m;
   assign req_op       = op_q;
   assign req_size     = sew_q;
   assign req_need_old = wb_q;
   assign done         = done_q;
   assign illegal      = illegal_q;
   assign rsp_fire     = busy && rsp_valid && (rsp_q != IW'(NELEM));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         iss_q     <= '0;
         rsp_q     <= '0;
         act_q     <= '0;
         base_q    <= '0;
         eew_q     <= '0;
         sew_q     <= '0;
         op_q      <= '0;
         wb_q      <= 1'b0;
         done_q    <= 1'b0;
         illegal_q <= 1'b0;
         for (int i = 0; i < NELEM; i++) begin
            off_q[i] <= '0;
            src_q[i] <= '0;
            dst_q[i] <= '0;
         end
      end else begin
         done_q    <= 1'b0;
         illegal_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (start) begin
                  if (dec_bad) begin
                     done_q    <= 1'b1;
                     illegal_q <= 1'b1;
                  end else begin
                     state_q <= ST_RUN;
                     iss_q   <= first_idx;
                     rsp_q   <= first_idx;
                     act_q   <= act_in;
                     base_q  <= base_addr;
                     eew_q   <= dec_eew;
                     sew_q   <= sew_code;
                     op_q    <= amo_op;
                     wb_q    <= wr_back;
                     for (int i = 0; i < NELEM; i++) begin
                        off_q[i] <= offsets[i*OFF_LANE +: OFF_LANE];
                        src_q[i] <= src_data[i*XLEN +: XLEN];
                        dst_q[i] <= dst_init[i*XLEN +: XLEN];
                     end
                  end
               end
            end
            default: begin
               if (req_valid && req_ready) iss_q <= iss_nx;
               if (rsp_fire) begin
                  rsp_q <= rsp_nx;
                  if (wb_q) dst_q[rsp_lane] <= (dst_q[rsp_lane] & ~sew_m) | (rsp_data & sew_m);
               end
               if (rsp_q == IW'(NELEM)) begin
                  done_q  <= 1'b1;
                  state_q <= ST_IDLE;
               end
            end
         endcase
      end
   end

   generate
      for (genvar g = 0; g < NELEM; g++) begin : g_dst
         assign dst_out[g*XLEN +: XLEN] = dst_q[g];
      end
   endgenerate

endmodule

// File: rtl/vamo_seq_checker.sv
module vamo_seq_checker #(
   parameter int XLEN  = 64,
   parameter int NELEM = 8
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  start,
   input logic                  wr_back,
   input logic [4:0]            amo_op,
   input logic                  busy,
   input logic                  done,
   input logic                  illegal,
   input logic                  req_valid,
   input logic                  req_ready,
   input logic [XLEN-1:0]       req_addr,
   input logic [XLEN-1:0]       req_data,
   input logic [4:0]            req_op,
   input logic                  req_need_old,
   input logic                  rsp_valid,
   input logic [NELEM*XLEN-1:0] dst_out
);
   localparam int CW = $clog2(NELEM + 1) + 1;

   logic          wb_cap;
   logic [4:0]    op_cap;
   logic [CW-1:0] outst;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wb_cap <= 1'b0;
         op_cap <= '0;
         outst  <= '0;
      end else begin
         if (start && !busy) begin
            wb_cap <= wr_back;
            op_cap <= amo_op;
         end
         outst <= outst + CW'(req_valid && req_ready) - CW'(rsp_valid);
      end
   end

   p_hold_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_data));

   p_illegal_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> done && !req_valid && !busy);

   p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_drained_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> outst == '0);

   p_idle_no_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !req_valid);

   p_need_old_r6: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> req_need_old == wb_cap);

   p_op_forward_r10: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> req_op == op_cap);

   p_dst_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !wb_cap |=> $stable(dst_out));

   p_rsp_expected_r11: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> outst != '0);

endmodule

bind vamo_seq vamo_seq_checker #(.XLEN(XLEN), .NELEM(NELEM)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .start        (start),
   .wr_back      (wr_back),
   .amo_op       (amo_op),
   .busy         (busy),
   .done         (done),
   .illegal      (illegal),
   .req_valid    (req_valid),
   .req_ready    (req_ready),
   .req_addr     (req_addr),
   .req_data     (req_data),
   .req_op       (req_op),
   .req_need_old (req_need_old),
   .rsp_valid    (rsp_valid),
   .dst_out      (dst_out)
);

// File: tb/vamo_seq_tb.sv
module vamo_seq_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NE = 8;
   localparam int N32 = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD / 2) clk = ~clk;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   // main instance (XLEN=64)
   logic              start = 0, mask_en = 0, wr_back = 0;
   logic [2:0]        width_code = 0;
   logic [4:0]        amo_op = 0;
   logic [63:0]       base_addr = 0;
   logic [1:0]        sew_code = 0;
   logic [3:0]        vec_len = 0;
   logic [NE-1:0]     mask_bits = 0;
   logic [NE*64-1:0]  offsets = 0, src_data = 0, dst_init = 0, dst_out;
   logic              busy, done, illegal, req_valid, req_need_old;
   logic              req_ready = 0, rsp_valid = 0;
   logic [63:0]       req_addr, req_data, rsp_data = 0;
   logic [4:0]        req_op;
   logic [1:0]        req_size;

   vamo_seq #(.XLEN(64), .NELEM(NE), .OFF_LANE(64)) dut_i (
      .clk, .rst_n, .start, .width_code, .amo_op, .mask_en, .wr_back, .base_addr,
      .sew_code, .vec_len, .mask_bits, .offsets, .src_data, .dst_init,
      .busy, .done, .illegal, .req_valid, .req_ready, .req_addr, .req_op,
      .req_data, .req_size, .req_need_old, .rsp_valid, .rsp_data, .dst_out
   );

   // narrow instance (XLEN=32) for the width-dependent reserved cases
   logic              s_start = 0;
   logic [2:0]        s_width = 0;
   logic [1:0]        s_sew = 0;
   logic              s_busy, s_done, s_illegal, s_req_valid, s_need_old;
   logic [31:0]       s_req_addr, s_req_data;
   logic [4:0]        s_req_op;
   logic [1:0]        s_req_size;
   logic [N32*32-1:0] s_dst_out;

   vamo_seq #(.XLEN(32), .NELEM(N32), .OFF_LANE(64)) dut32_i (
      .clk, .rst_n, .start(s_start), .width_code(s_width), .amo_op(5'd0),
      .mask_en(1'b0), .wr_back(1'b1), .base_addr(32'h100), .sew_code(s_sew),
      .vec_len(3'd4), .mask_bits(4'hF), .offsets('0), .src_data('0), .dst_init('0),
      .busy(s_busy), .done(s_done), .illegal(s_illegal), .req_valid(s_req_valid),
      .req_ready(1'b1), .req_addr(s_req_addr), .req_op(s_req_op), .req_data(s_req_data),
      .req_size(s_req_size), .req_need_old(s_need_old), .rsp_valid(1'b0),
      .rsp_data(32'h0), .dst_out(s_dst_out)
   );

   // memory model state and request log
   bit          stall = 0;
   int          qw = 0, qr = 0, log_n = 0;
   logic [63:0] rq [64];
   logic [63:0] log_addr [64], log_data [64];
   logic [4:0]  log_op [64];
   logic [1:0]  log_size [64];
   logic        log_need [64];
   int          log_cyc [64];
   logic [63:0] t_off [NE], t_src [NE], t_dst [NE];

   function automatic logic [63:0] mem_old(input logic [63:0] a);
      return {~a[31:0], a[31:0] ^ 32'h5A5A_3C3C};
   endfunction

   function automatic logic [63:0] bits_mask(input int w);
      return (w >= 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 64'd1);
   endfunction

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   initial forever begin
      @(posedge clk);
      cyc++;
   end

   // responder: ready decided, request logged, queued responses returned
   initial forever begin
      @(negedge clk);
      req_ready = stall ? ((cyc % 3) != 0) : 1'b1;
      if (qr < qw) begin
         rsp_valid = 1'b1;
         rsp_data  = rq[qr];
         qr++;
      end else begin
         rsp_valid = 1'b0;
      end
      if (req_valid && req_ready && log_n < 64) begin
         log_addr[log_n] = req_addr;
         log_data[log_n] = req_data;
         log_op[log_n]   = req_op;
         log_size[log_n] = req_size;
         log_need[log_n] = req_need_old;
         log_cyc[log_n]  = cyc;
         log_n++;
         rq[qw] = mem_old(req_addr);
         qw++;
      end
   end

   // pulse start and return how many cycles later done was seen
   task automatic pulse_wait(output int waited);
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      waited = 0;
      while (!done && waited < 200) begin
         @(negedge clk);
         waited++;
      end
   endtask

   task automatic run_vec(input logic [2:0] wc, input logic [4:0] op, input bit me, input bit wb,
                          input logic [63:0] base, input logic [1:0] sew, input int vl,
                          input logic [NE-1:0] mk, input bit stl, input string tag);
      int waited, eew, k, nact;
      logic [63:0] sm, exp_addr, exp_dst;
      bit act;
      @(negedge clk);
      qw = 0; qr = 0; log_n = 0; stall = stl;
      width_code = wc; amo_op = op; mask_en = me; wr_back = wb; base_addr = base;
      sew_code = sew; vec_len = 4'(vl); mask_bits = mk;
      for (int i = 0; i < NE; i++) begin
         offsets[i*64 +: 64]  = t_off[i];
         src_data[i*64 +: 64] = t_src[i];
         dst_init[i*64 +: 64] = t_dst[i];
      end
      pulse_wait(waited);
      chk(waited < 200, {tag, " R11 done seen"}, 64'(waited), 64'd0);
      chk(illegal == 1'b0, {tag, " R2 no illegal on legal insn"}, 64'(illegal), 64'd0);
      repeat (3) @(negedge clk);
      case (wc)
         3'b000: eew = 8;
         3'b101: eew = 16;
         3'b110: eew = 32;
         default: eew = 64;
      endcase
      sm = bits_mask(8 << sew);
      k = 0; nact = 0;
      for (int i = 0; i < NE; i++) begin
         act = (i < vl) && (!me || mk[i]);
         exp_addr = base + (t_off[i] & bits_mask(eew));
         exp_dst  = t_dst[i];
         if (act) begin
            nact++;
            if (wb) exp_dst = (t_dst[i] & ~sm) | (mem_old(exp_addr) & sm);
            if (k < log_n) begin
               chk(log_addr[k] == exp_addr, {tag, " R1 address"}, log_addr[k], exp_addr);
               chk(log_data[k] == (t_src[i] & sm), {tag, " R10 data"}, log_data[k], t_src[i] & sm);
               chk(log_op[k] == op && log_size[k] == sew, {tag, " R10 op/size"},
                   {57'd0, log_op[k], log_size[k]}, {57'd0, op, sew});
               chk(log_need[k] == wb, {tag, " R6 need-old"}, 64'(log_need[k]), 64'(wb));
               if (k > 0 && !stl)
                  chk(log_cyc[k] - log_cyc[k-1] == 1, {tag, " R8 back-to-back"},
                      64'(log_cyc[k] - log_cyc[k-1]), 64'd1);
            end
            k++;
         end
         chk(dst_out[i*64 +: 64] == exp_dst, {tag, " R5/R6/R7/R9 destination lane"},
             dst_out[i*64 +: 64], exp_dst);
      end
      chk(log_n == nact, {tag, " R7/R9 request count"}, 64'(log_n), 64'(nact));
   endtask

   task automatic t_reset();
      chk(!busy && !done && !illegal && !req_valid, "reset idle outputs R11",
          {60'd0, busy, done, illegal, req_valid}, 64'd0);
      chk(dst_out == '0, "reset destination R5", dst_out[63:0], 64'd0);
   endtask

   task automatic fill(input logic [63:0] seed);
      for (int i = 0; i < NE; i++) begin
         t_off[i] = 64'hDEAD_BEEF_0000_0000 | (seed ^ 64'(i * 24 + 8)) | (64'h1_0000 << i);
         t_src[i] = {32'hC0DE_0000 + 32'(i), 32'h1234_5600 + 32'(i)} ^ seed;
         t_dst[i] = 64'hAAAA_5555_0000_0000 + 64'(i) * 64'h0101 + seed;
      end
   endtask

   task automatic t_eew8_wb();
      fill(64'h11);
      run_vec(3'b000, 5'b00000, 1'b0, 1'b1, 64'h0000_0000_8000_0000, 2'd3, 8, 8'h00, 1'b0, "eew8 wb");
   endtask

   task automatic t_eew16_nowb();
      fill(64'h2222);
      run_vec(3'b101, 5'b00001, 1'b0, 1'b0, 64'h0000_1000_0000_0040, 2'd2, 6, 8'hFF, 1'b0, "eew16 no-wb R9");
   endtask

   task automatic t_eew32_mask();
      fill(64'h3300_0044);
      run_vec(3'b110, 5'b01100, 1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_FF00, 2'd3, 8, 8'b1011_0110, 1'b1, "eew32 mask stall R7 R8");
   endtask

   task automatic t_eew64_sew32();
      fill(64'h4400_0000_0000_0004);
      run_vec(3'b111, 5'b11100, 1'b0, 1'b1, 64'h0000_0000_0000_1000, 2'd2, 8, 8'h00, 1'b0, "eew64 sew32 R5");
   endtask

   task automatic t_no_active();
      int waited;
      fill(64'h55);
      run_vec(3'b000, 5'b00100, 1'b1, 1'b1, 64'h2000, 2'd3, 8, 8'h00, 1'b0, "empty mask R7");
      @(negedge clk);
      mask_en = 1'b1; mask_bits = 8'h00;
      pulse_wait(waited);
      chk(waited == 1, "R11 done one cycle after RUN with nothing to do", 64'(waited), 64'd1);
      mask_en = 1'b0; vec_len = 4'd0;
      pulse_wait(waited);
      chk(waited == 1 && log_n == 0, "R9 zero vector length", 64'(waited), 64'd1);
   endtask

   task automatic t_bad_width();
      int waited;
      logic [2:0] codes [4] = '{3'b001, 3'b010, 3'b011, 3'b100};
      foreach (codes[j]) begin
         @(negedge clk);
         log_n = 0; width_code = codes[j]; sew_code = 2'd3; vec_len = 4'd8; mask_en = 1'b0;
         pulse_wait(waited);
         chk(waited == 0 && illegal, "R2 reserved width code flagged", {61'd0, codes[j]}, 64'd0);
         @(negedge clk);
         chk(!busy && log_n == 0 && !done, "R2 no request for reserved code", 64'(log_n), 64'd0);
      end
   endtask

   task automatic t_bad_sew();
      int waited;
      for (int s = 0; s < 2; s++) begin
         @(negedge clk);
         log_n = 0; width_code = 3'b000; sew_code = 2'(s); vec_len = 4'd8;
         pulse_wait(waited);
         chk(waited == 0 && illegal && log_n == 0, "R4 narrow SEW reserved", 64'(s), 64'd0);
      end
   endtask

   task automatic t_narrow_xlen();
      int waited;
      @(negedge clk);
      s_width = 3'b111; s_sew = 2'd2; s_start = 1'b1;
      @(negedge clk);
      s_start = 1'b0;
      chk(s_done && s_illegal && !s_req_valid, "R3 64-bit offset with XLEN 32", {62'd0, s_done, s_illegal}, 64'd3);
      @(negedge clk);
      s_width = 3'b110; s_sew = 2'd3; s_start = 1'b1;
      @(negedge clk);
      s_start = 1'b0;
      chk(s_done && s_illegal && !s_busy, "R4 64-bit SEW with XLEN 32", {62'd0, s_done, s_illegal}, 64'd3);
      waited = 0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_eew8_wb();
      t_eew16_nowb();
      t_eew32_mask();
      t_eew64_sew32();
      t_no_active();
      t_bad_width();
      t_bad_sew();
      t_narrow_xlen();
      repeat (2) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule